// File: doc/BRIEF.md
# Variable Block Size SAD Merger

This block sits behind a motion-search engine that delivers, for each candidate search position, the sixteen 4x4 sums of absolute differences of one 16x16 macroblock, together with the motion vector of that position. From those sixteen values it builds, in the same cycle, the SADs of every larger partition shape: 8x4, 4x8, 8x8, 16x8, 8x16 and 16x16. That gives 41 partitions in total.

Each partition owns a minimum register. The register holds the lowest SAD seen since the last start, together with the motion vector that produced it. A search begins with a start pulse. The engine then presents one position per valid cycle. A done pulse freezes every register and raises a flag, after which the best SAD and vector of all 41 partitions can be read in parallel.

Top module: `vbs_sad_merge`

## Requirements
- R1: While reset (active-low, synchronous) is applied, and after it is released, every best SAD reads all ones (16'hFFFF), every best motion vector reads zero and `results_valid_o` is low.
- R2: Partitions 0..15 are the 4x4 sub-blocks in raster order: sub-block 0..3 is the top row and index 4*row+col. Their candidate SAD is the input value zero-extended to 16 bits. Input sub-block i occupies `sad4_i[12*i +: 12]`.
- R3: Partitions 16..23 are the 8x4 blocks, each pairing a horizontally adjacent couple. Partition 16+k sums sub-blocks b and b+1, where b = 4*(k/2) + 2*(k%2).
- R4: Partitions 24..31 are the 4x8 blocks, each pairing a vertically adjacent couple. Partition 24+k sums sub-blocks b and b+4, where b = 8*(k/4) + (k%4).
- R5: Partitions 32..35 are the 8x8 quadrants in raster order. Quadrant q sums sub-blocks b, b+1, b+4 and b+5, where b = 8*(q/2) + 2*(q%2).
- R6: Partition 36 is the top 16x8 half and 37 the bottom half. Partition 38 is the left 8x16 half and 39 the right half. Partition 40 is the full 16x16 block. All sums are 16 bits wide and do not overflow, even when every 4x4 input is 4095. Partition p is read at `best_sad_o[16*p +: 16]` and `best_mv_o[8*p +: 8]`.
- R7: A partition's register is replaced only when its new candidate SAD is strictly lower than the stored one. On equal SADs, the vector of the earlier position is kept.
- R8: A start pulse returns every best SAD to all ones and every vector to zero, and clears `results_valid_o`, on the next edge. A valid strobe in the same cycle as start is discarded.
- R9: A done pulse raises `results_valid_o` on the next edge. From then on, valid strobes leave every result unchanged until the next start.
- R10: A cycle with `valid_i` low leaves every best SAD and vector unchanged, whatever the data inputs carry.
- R11: A position accepted at a clock edge is reflected in the outputs immediately after that edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begins a search and clears all minimum registers |
| done_i | input | 1 | Ends a search and freezes the results |
| valid_i | input | 1 | The SAD set and vector of one position are present |
| mv_i | input | 8 | Motion vector of the presented position |
| sad4_i | input | 192 | Sixteen 12-bit 4x4 SADs, sub-block i at bits 12*i +: 12 |
| best_sad_o | output | 656 | Best SAD of each of the 41 partitions, 16 bits each |
| best_mv_o | output | 328 | Winning vector of each of the 41 partitions, 8 bits each |
| results_valid_o | output | 1 | Results are frozen and final |

## Verification
A sub-block wired to the wrong neighbour in the adder tree changes only the partitions built from that neighbour. It shows up at the first position where the two sub-blocks differ, as a wrong best SAD in that partition. A flipped comparison, or an off-by-one tie rule, appears as a wrong vector once two positions compete for the same partition. Over a few hundred random positions this happens within the first handful. Freeze or clear faults show up one edge after done or start, as values that move or do not reset.

// File: rtl/vbs_pkg.sv
// Shared constants of the variable block size SAD merger.
// Assumes a 16x16 macroblock split into a 4x4 grid of 4x4 sub-blocks.
package vbs_pkg;
    localparam int N_SUB   = 16;  // 4x4 sub-blocks per macroblock
    localparam int N_H84   = 8;   // 8x4 partitions
    localparam int N_V48   = 8;   // 4x8 partitions
    localparam int N_Q88   = 4;   // 8x8 partitions
    localparam int N_PART  = 41;  // all partitions
    // Base index of each shape in the partition numbering
    localparam int P_H84   = 16;
    localparam int P_V48   = 24;
    localparam int P_Q88   = 32;
    localparam int P_H168  = 36;
    localparam int P_V816  = 38;
    localparam int P_FULL  = 40;
endpackage

// File: rtl/vbs_part_sum.sv
// Combinational adder tree: forms the SADs of all 41 partitions from the
// sixteen 4x4 SADs of one search position. Larger shapes reuse the sums of
// the smaller ones. Assumes SUM_W is wide enough for the 16-input total.
module vbs_part_sum
    import vbs_pkg::*;
#(
    parameter int SAD4_W = 12,
    parameter int SUM_W  = SAD4_W + $clog2(N_SUB)
) (
    input  logic [N_SUB-1:0][SAD4_W-1:0] sad4,
    output logic [N_PART-1:0][SUM_W-1:0] sums
);
    logic [SUM_W-1:0] s44  [N_SUB];
    logic [SUM_W-1:0] s84  [N_H84];
    logic [SUM_W-1:0] s48  [N_V48];
    logic [SUM_W-1:0] s88  [N_Q88];
    logic [SUM_W-1:0] s168 [2];
    logic [SUM_W-1:0] s816 [2];
    logic [SUM_W-1:0] s1616;

    // 4x4 level: zero-extend the inputs
    for (genvar i = 0; i < N_SUB; i++) begin : g_s44
        assign s44[i] = SUM_W'(sad4[i]);
        assign sums[i] = s44[i];
    end

    // 8x4 level: horizontal pairs
    for (genvar k = 0; k < N_H84; k++) begin : g_s84
        localparam int HB = 4 * (k / 2) + 2 * (k % 2);
        assign s84[k] = s44[HB] + s44[HB+1];
        assign sums[P_H84+k] = s84[k];
    end

    // 4x8 level: vertical pairs
    for (genvar k = 0; k < N_V48; k++) begin : g_s48
        localparam int VB = 8 * (k / 4) + (k % 4);
        assign s48[k] = s44[VB] + s44[VB+4];
        assign sums[P_V48+k] = s48[k];
    end

    // 8x8 level: two stacked 8x4 blocks per quadrant
    for (genvar q = 0; q < N_Q88; q++) begin : g_s88
        localparam int TOP = 4 * (q / 2) + (q % 2);
        assign s88[q] = s84[TOP] + s84[TOP+2];
        assign sums[P_Q88+q] = s88[q];
    end

    // Half and full macroblock levels
    for (genvar h = 0; h < 2; h++) begin : g_half
        assign s168[h] = s88[2*h] + s88[2*h+1];
        assign s816[h] = s88[h] + s88[h+2];
        assign sums[P_H168+h] = s168[h];
        assign sums[P_V816+h] = s816[h];
    end
    assign s1616 = s168[0] + s168[1];
    assign sums[P_FULL] = s1616;
endmodule

// File: rtl/vbs_min_latch.sv
// One partition's minimum register: holds the lowest SAD since the last
// clear and the vector that produced it. Strictly-lower replaces, so ties
// keep the earlier vector. Assumes the caller gates upd_en.
module vbs_min_latch #(
    parameter int SUM_W = 16,
    parameter int MV_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             upd_en,
    input  logic [SUM_W-1:0] cand_sad,
    input  logic [MV_W-1:0]  cand_mv,
    output logic [SUM_W-1:0] best_sad,
    output logic [MV_W-1:0]  best_mv
);
    // Clear to all ones, otherwise keep the strict minimum
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            best_sad <= '1;
            best_mv  <= '0;
        end else if (upd_en && (cand_sad < best_sad)) begin
            best_sad <= cand_sad;
            best_mv  <= cand_mv;
        end
    end
endmodule

// File: rtl/vbs_sad_merge.sv
// Top of the variable block size SAD merger. It builds all partition SADs
// for each accepted position and keeps the per-partition minimum. Start
// clears, done freezes. Assumes one position per valid cycle.
module vbs_sad_merge
    import vbs_pkg::*;
#(
    parameter int SAD4_W = 12,
    parameter int MV_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic                       done_i,
    input  logic                       valid_i,
    input  logic [MV_W-1:0]            mv_i,
    input  logic [N_SUB*SAD4_W-1:0]    sad4_i,
    output logic [N_PART*(SAD4_W+4)-1:0] best_sad_o,
    output logic [N_PART*MV_W-1:0]     best_mv_o,
    output logic                       results_valid_o
);
    localparam int SUM_W = SAD4_W + $clog2(N_SUB);

    logic [N_SUB-1:0][SAD4_W-1:0] sad4_arr;
    logic [N_PART-1:0][SUM_W-1:0] part_sums;
    logic                         accept;

    assign sad4_arr = sad4_i;
    assign accept   = valid_i && !results_valid_o && !start_i;

    vbs_part_sum #(.SAD4_W(SAD4_W), .SUM_W(SUM_W)) tree_i (
        .sad4 (sad4_arr),
        .sums (part_sums)
    );

    for (genvar p = 0; p < N_PART; p++) begin : g_lat
        vbs_min_latch #(.SUM_W(SUM_W), .MV_W(MV_W)) lat_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (start_i),
            .upd_en   (accept),
            .cand_sad (part_sums[p]),
            .cand_mv  (mv_i),
            .best_sad (best_sad_o[p*SUM_W +: SUM_W]),
            .best_mv  (best_mv_o[p*MV_W +: MV_W])
        );
    end

    // Freeze flag: set by done, cleared by start
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) results_valid_o <= 1'b0;
        else if (done_i)       results_valid_o <= 1'b1;
    end
endmodule

// File: rtl/vbs_sad_merge_chk.sv
// Checker for vbs_sad_merge, attached by bind. It observes only the ports.
module vbs_sad_merge_chk
    import vbs_pkg::*;
#(
    parameter int SAD4_W = 12,
    parameter int MV_W   = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       start_i,
    input logic                       done_i,
    input logic                       valid_i,
    input logic [MV_W-1:0]            mv_i,
    input logic [N_SUB*SAD4_W-1:0]    sad4_i,
    input logic [N_PART*(SAD4_W+4)-1:0] best_sad_o,
    input logic [N_PART*MV_W-1:0]     best_mv_o,
    input logic                       results_valid_o
);
    localparam int SUM_W = SAD4_W + 4;

    logic [SUM_W-1:0] in_total;
    // Total of all sixteen inputs, for the 16x16 bound
    always_comb begin
        in_total = '0;
        for (int i = 0; i < N_SUB; i++)
            in_total = in_total + SUM_W'(sad4_i[i*SAD4_W +: SAD4_W]);
    end

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!results_valid_o && (&best_sad_o) && (best_mv_o == '0)));

    assert_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !start_i) |=> results_valid_o);

    assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (results_valid_o && !start_i) |=> ($stable(best_sad_o) && $stable(best_mv_o)));

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && !start_i) |=> ($stable(best_sad_o) && $stable(best_mv_o)));

    assert_full_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !start_i && !results_valid_o) |=>
            (best_sad_o[P_FULL*SUM_W +: SUM_W] <= $past(in_total)));

    for (genvar i = 0; i < N_SUB; i++) begin : g_sub
        assert_sub_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_i && !start_i && !results_valid_o) |=>
                (best_sad_o[i*SUM_W +: SUM_W] <= SUM_W'($past(sad4_i[i*SAD4_W +: SAD4_W]))));
    end

    for (genvar p = 0; p < N_PART; p++) begin : g_part
        assert_monotone_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(start_i) |->
                (best_sad_o[p*SUM_W +: SUM_W] <= $past(best_sad_o[p*SUM_W +: SUM_W])));
        assert_mv_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(start_i) && (best_sad_o[p*SUM_W +: SUM_W] != $past(best_sad_o[p*SUM_W +: SUM_W])))
                |-> (best_mv_o[p*MV_W +: MV_W] == $past(mv_i)));
    end
endmodule

bind vbs_sad_merge vbs_sad_merge_chk #(.SAD4_W(SAD4_W), .MV_W(MV_W)) chk_i (.*);

// File: tb/vbs_sad_merge_tb_top.sv
module vbs_sad_merge_tb_top;
    localparam int SAD4_W = 12;
    localparam int MV_W   = 8;
    localparam int SUM_W  = 16;
    localparam int NP     = 41;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, done_i = 1'b0, valid_i = 1'b0;
    logic [MV_W-1:0] mv_i = '0;
    logic [16*SAD4_W-1:0] sad4_i = '0;
    logic [NP*SUM_W-1:0] best_sad_o;
    logic [NP*MV_W-1:0] best_mv_o;
    logic results_valid_o;

    int n_tests = 0, n_fail = 0;
    int ref_sad [NP];
    int ref_mv  [NP];
    bit ref_frozen = 0;
    int cur [16];

    always #5 clk = ~clk;

    vbs_sad_merge #(.SAD4_W(SAD4_W), .MV_W(MV_W)) dut_i (.*);

    function automatic string tag_of(int p);
        if (p < 16) return "R2";
        if (p < 24) return "R3";
        if (p < 32) return "R4";
        if (p < 36) return "R5";
        return "R6";
    endfunction

    // Expected SAD of partition p from the current sixteen values
    function automatic int part_val(int p);
        int b;
        if (p < 16) return cur[p];
        if (p < 24) begin b = 4*((p-16)/2) + 2*((p-16)%2); return cur[b] + cur[b+1]; end
        if (p < 32) begin b = 8*((p-24)/4) + ((p-24)%4); return cur[b] + cur[b+4]; end
        if (p < 36) begin b = 8*((p-32)/2) + 2*((p-32)%2);
            return cur[b] + cur[b+1] + cur[b+4] + cur[b+5]; end
        if (p == 36) return part_val(32) + part_val(33);
        if (p == 37) return part_val(34) + part_val(35);
        if (p == 38) return part_val(32) + part_val(34);
        if (p == 39) return part_val(33) + part_val(35);
        return part_val(36) + part_val(37);
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int p = 0; p < NP; p++) begin ref_sad[p] = 65535; ref_mv[p] = 0; end
        ref_frozen = 0;
    endtask

    task automatic check_all(string what);
        for (int p = 0; p < NP; p++) begin
            check(best_sad_o[p*SUM_W +: SUM_W] == SUM_W'(ref_sad[p]), tag_of(p),
                  $sformatf("%s sad p%0d", what, p), int'(best_sad_o[p*SUM_W +: SUM_W]), ref_sad[p]);
            check(best_mv_o[p*MV_W +: MV_W] == MV_W'(ref_mv[p]), "R7",
                  $sformatf("%s mv p%0d", what, p), int'(best_mv_o[p*MV_W +: MV_W]), ref_mv[p]);
        end
    endtask

    task automatic load_cur();
        for (int i = 0; i < 16; i++) sad4_i[i*SAD4_W +: SAD4_W] = SAD4_W'(cur[i]);
    endtask

    // Present one position for one cycle and update the model
    task automatic push(int mv);
        @(negedge clk);
        load_cur();
        mv_i = MV_W'(mv);
        valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        if (!ref_frozen)
            for (int p = 0; p < NP; p++)
                if (part_val(p) < ref_sad[p]) begin ref_sad[p] = part_val(p); ref_mv[p] = mv; end
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        model_clear();
    endtask

    task automatic pulse_done();
        @(negedge clk); done_i = 1'b1;
        @(negedge clk); done_i = 1'b0;
        ref_frozen = 1;
    endtask

    initial begin
        #(10 * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_clear();
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!results_valid_o, "R1", "results_valid after reset", int'(results_valid_o), 0);
        check_all("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release");

        // R11 and R6: single position with all-max inputs, seen one edge later
        pulse_start();
        for (int i = 0; i < 16; i++) cur[i] = 4095;
        push(3);
        check(best_sad_o[40*SUM_W +: SUM_W] == 16'd65520, "R6", "16x16 at max", int'(best_sad_o[40*SUM_W +: SUM_W]), 65520);
        check_all("R11 first position");

        // R10: inputs change while valid low
        @(negedge clk);
        for (int i = 0; i < 16; i++) sad4_i[i*SAD4_W +: SAD4_W] = '0;
        mv_i = 8'd99;
        repeat (2) @(negedge clk);
        check_all("R10 idle");

        // R7: equal SAD keeps earlier vector, lower replaces
        pulse_start();
        for (int i = 0; i < 16; i++) cur[i] = 100;
        push(5);
        push(6);
        check(best_mv_o[40*MV_W +: MV_W] == 8'd5, "R7", "tie keeps earlier", int'(best_mv_o[40*MV_W +: MV_W]), 5);
        cur[0] = 99;
        push(7);
        check_all("R7 ties");

        // R8: start with valid in the same cycle is discarded
        @(negedge clk);
        for (int i = 0; i < 16; i++) cur[i] = 1;
        load_cur(); mv_i = 8'd9; valid_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0; start_i = 1'b0;
        model_clear();
        check_all("R8 start over valid");

        // Directed: distinct per sub-block values expose pairing errors (R2..R6)
        for (int i = 0; i < 16; i++) cur[i] = (i + 1) * (i + 3);
        push(11);
        check_all("R3 R4 R5 distinct");

        // Random search of 256 positions, then done (R2..R7, R9)
        pulse_start();
        for (int pos = 0; pos < 256; pos++) begin
            for (int i = 0; i < 16; i++)
                cur[i] = (pos < 128) ? int'($urandom % 4096) : int'($urandom % 64);
            push(pos);
        end
        pulse_done();
        check(results_valid_o, "R9", "results_valid after done", int'(results_valid_o), 1);
        check_all("random search");

        // R9: frozen results ignore valid
        for (int i = 0; i < 16; i++) cur[i] = 0;
        push(200);
        push(201);
        check_all("R9 frozen");

        // R8: start clears frozen results
        pulse_start();
        check(!results_valid_o, "R8", "results_valid after start", int'(results_valid_o), 0);
        check_all("R8 cleared");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule